// File: doc/BRIEF.md
# Cascadable Dual 8-bit Event Counter

The block contains two 8-bit up-counters, a low counter and a high counter. Each one counts events from a source that software selects. The choices are an external event pin that runs without any relation to the system clock, or the system clock divided by 2, 4 or 8. The high counter has one more choice: the overflow of the low counter. With that choice the two counters form a single 16-bit counter. The low byte sits in the low counter and the high byte in the high counter.

Software writes two registers: a control register and a source-select register. Each counter has a level-sensitive reset-control bit, and the counter stays at zero while that bit is 0. The low counter also has a count-enable bit. When it is 0, the low counter keeps its value and ignores events. Both counters can be read through a combinational register read port, but they cannot be written. Each event pin passes through a two-flop synchronizer. An edge detector then turns each rising edge into one count pulse in the system clock domain. The divided-clock sources are single-cycle enable pulses taken from a free-running 3-bit prescaler.

Top module: `dual_event_counter`

## Requirements
- R1: After reset, both counters read 0x00, the control register reads 0x00 and the source-select register reads 0x00.
- R2: While control bit 0 (low reset-control) is 0, the low counter reads 0x00 and ignores every event.
- R3: While control bit 1 (high reset-control) is 0, the high counter reads 0x00 and ignores every event.
- R4: While control bit 2 (low count-enable) is 0 and bit 0 is 1, the low counter keeps its value when events arrive.
- R5: When a counter's source is its event pin (select code 0), each rising edge on that pin adds exactly 1. Holding the pin high adds nothing more.
- R6: Select codes 1, 2 and 3 choose the system clock divided by 2, 4 and 8. Over any 32 consecutive clock cycles the counter advances by exactly 16, 8 and 4.
- R7: The low counter wraps from 0xFF to 0x00.
- R8: With high select code 4 (cascade), the high counter adds 1 on the same clock edge on which the low counter wraps. A 16-bit count therefore goes from 0x00FF to 0x0100.
- R9: Writes use address 0 for control bits [2:0] and address 1 for source select. In source select, bits [2:0] hold the high-counter code and bits [4:3] hold the low-counter code. Read addresses are 0 for control, 1 for source select, 2 for the low counter and 3 for the high counter.
- R10: High select codes 5, 6 and 7 choose no source, and the high counter then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_hi_pin | input | 1 | Asynchronous event input for the high counter |
| evt_lo_pin | input | 1 | Asynchronous event input for the low counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 source select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
The assertions assume that reset is applied at the start of the run. They also assume that counter-width arithmetic wraps naturally, so no step is larger than one per cycle. The bench never drives a pin edge and a control write within the same few cycles. Each pin pulse is held high for four cycles and then low for four, so the synchronizer catches every edge, and the bench waits for a pulse to finish before it reads or writes. Random runs choose control values freely. The high source alternates between the pin and the cascade, so the bench model can predict every count exactly.

// File: rtl/dual_event_counter.sv
module dual_event_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_hi_pin,
  input  logic         evt_lo_pin,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [7:0]   wr_data,
  input  logic [1:0]   rd_addr,
  output logic [7:0]   rd_data
);
  localparam logic [W-1:0] TOP = '1;

  logic [2:0]   ctrl;
  logic [2:0]   hsel;
  logic [1:0]   lsel;
  logic [2:0]   hs, ls;
  logic [2:0]   pre;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic         hpulse, lpulse, d2, d4, d8;
  logic         lo_tick, hi_tick, lo_inc, lo_ovf, hi_inc;

  wire lo_run = ctrl[0];
  wire hi_run = ctrl[1];
  wire lo_en  = ctrl[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      hsel <= '0;
      lsel <= '0;
    end else if (wr_en) begin
      if (!wr_addr) ctrl <= wr_data[2:0];
      else begin
        hsel <= wr_data[2:0];
        lsel <= wr_data[4:3];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs  <= '0;
      ls  <= '0;
      pre <= '0;
    end else begin
      hs  <= {hs[1:0], evt_hi_pin};
      ls  <= {ls[1:0], evt_lo_pin};
      pre <= pre + 3'd1;
    end

  assign hpulse = hs[1] & ~hs[2];
  assign lpulse = ls[1] & ~ls[2];
  assign d2 = pre[0];
  assign d4 = &pre[1:0];
  assign d8 = &pre;

  always_comb
    case (lsel)
      2'd0:    lo_tick = lpulse;
      2'd1:    lo_tick = d2;
      2'd2:    lo_tick = d4;
      default: lo_tick = d8;
    endcase

  assign lo_inc = lo_tick & lo_en & lo_run;
  assign lo_ovf = lo_inc & (cnt_lo == TOP);

  always_comb
    case (hsel)
      3'd0:    hi_tick = hpulse;
      3'd1:    hi_tick = d2;
      3'd2:    hi_tick = d4;
      3'd3:    hi_tick = d8;
      3'd4:    hi_tick = lo_ovf;
      default: hi_tick = 1'b0;
    endcase

  assign hi_inc = hi_tick & hi_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_lo <= '0;
    else if (!lo_run) cnt_lo <= '0;
    else if (lo_inc)  cnt_lo <= cnt_lo + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_hi <= '0;
    else if (!hi_run) cnt_hi <= '0;
    else if (hi_inc)  cnt_hi <= cnt_hi + 1'b1;

  always_comb
    case (rd_addr)
      2'd0:    rd_data = {5'd0, ctrl};
      2'd1:    rd_data = {3'd0, lsel, hsel};
      2'd2:    rd_data = 8'(cnt_lo);
      default: rd_data = 8'(cnt_hi);
    endcase

  AST_LO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_run |=> cnt_lo == '0); // R2
  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_run |=> cnt_hi == '0); // R3
  AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run && !lo_en) |=> $stable(cnt_lo)); // R4
  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + 1'b1)); // R7
  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel == 3'd4 && hi_run && lo_inc && cnt_lo == TOP) |=> (cnt_lo == '0 && cnt_hi == $past(cnt_hi) + 1'b1)); // R8
  AST_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel > 3'd4 && hi_run) |=> $stable(cnt_hi)); // R10
endmodule

// File: tb/tb_dual_event_counter.sv
module tb_dual_event_counter;
  logic clk = 0, rst_n = 0, evt_hi_pin = 0, evt_lo_pin = 0;
  logic wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  logic [7:0] m_lo, m_hi;
  logic [2:0] m_ctrl, m_hsel;

  dual_event_counter dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    cyc(2);
  endtask

  task automatic pulse(bit hi, bit lo);
    @(negedge clk);
    evt_hi_pin = hi; evt_lo_pin = lo;
    cyc(4);
    evt_hi_pin = 0; evt_lo_pin = 0;
    cyc(4);
  endtask

  function automatic logic [15:0] model_step(logic [7:0] lo, logic [7:0] hi,
      logic [2:0] c, logic [2:0] hsel, bit ph, bit pl);
    logic [7:0] nlo = lo, nhi = hi;
    bit ovf = 0;
    if (c[0] && c[2] && pl) begin
      ovf = (lo == 8'hFF);
      nlo = lo + 8'd1;
    end
    if (c[1] && ((hsel == 3'd0 && ph) || (hsel == 3'd4 && ovf))) nhi = hi + 8'd1;
    return {nhi, nlo};
  endfunction

  initial begin
    cyc(200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    logic [15:0] nm;
    int seed;
    seed = $urandom(32'h5EED1234);
    cyc(3);
    rst_n = 1;
    cyc(2);
    rd(2, a); chk("R1 lo", a, 8'h00);
    rd(3, a); chk("R1 hi", a, 8'h00);
    rd(0, a); chk("R1 ctrl", a, 8'h00);
    rd(1, a); chk("R1 sel", a, 8'h00);

    pulse(1, 1);
    rd(2, a); chk("R2 lo held", a, 8'h00);
    rd(3, a); chk("R3 hi held", a, 8'h00);

    wr(0, 8'h07);
    rd(0, a); chk("R9 ctrl readback", a, 8'h07);
    pulse(1, 1); pulse(1, 1); pulse(0, 1);
    rd(2, a); chk("R5 lo pin", a, 8'h03);
    rd(3, a); chk("R5 hi pin", a, 8'h02);

    @(negedge clk); evt_lo_pin = 1; cyc(20); evt_lo_pin = 0; cyc(4);
    rd(2, a); chk("R5 level no extra", a, 8'h04);

    wr(0, 8'h03);
    pulse(0, 1); pulse(0, 1);
    rd(2, a); chk("R4 enable off holds", a, 8'h04);

    wr(0, 8'h06);
    rd(2, a); chk("R2 lo cleared", a, 8'h00);
    rd(3, a); chk("R2 hi kept", a, 8'h02);
    wr(0, 8'h05);
    rd(3, a); chk("R3 hi cleared", a, 8'h00);

    for (int k = 1; k <= 3; k++) begin
      wr(1, 8'((k << 3) | k));
      wr(0, 8'h07);
      rd(1, a); chk("R9 sel readback", a, 8'((k << 3) | k));
      rd(2, a); rd(3, b);
      begin
        logic [7:0] a2, b2;
        cyc(32);
        rd(2, a2); rd(3, b2);
        chk("R6 lo divided", a2 - a, 8'(32 >> k));
        chk("R6 hi divided", b2 - b, 8'(32 >> k));
      end
    end

    for (int k = 5; k <= 7; k++) begin
      wr(1, 8'(k));
      rd(3, a); cyc(32); rd(3, b);
      chk("R10 no source", b, a);
    end

    wr(0, 8'h00); wr(1, 8'h04); wr(0, 8'h07);
    for (int i = 0; i < 255; i++) pulse(0, 1);
    rd(2, a); chk("R7 lo at FF", a, 8'hFF);
    rd(3, a); chk("R8 hi before carry", a, 8'h00);
    pulse(0, 1);
    rd(2, a); chk("R7 lo wrapped", a, 8'h00);
    rd(3, a); chk("R8 hi carried", a, 8'h01);

    wr(0, 8'h00);
    m_lo = 0; m_hi = 0; m_ctrl = 0; m_hsel = 0;
    wr(1, 8'h00);
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op == 0) begin
        m_ctrl = 3'($urandom_range(0, 7)) | 3'b001;
        if ($urandom_range(0, 3) == 0) m_ctrl = 3'($urandom_range(0, 7));
        wr(0, {5'd0, m_ctrl});
        if (!m_ctrl[0]) m_lo = 0;
        if (!m_ctrl[1]) m_hi = 0;
      end else if (op == 1) begin
        m_hsel = $urandom_range(0, 1) ? 3'd4 : 3'd0;
        wr(1, {5'd0, m_hsel});
      end else begin
        bit ph = 1'($urandom_range(0, 1));
        bit pl = 1'($urandom_range(0, 3) != 0);
        pulse(ph, pl);
        nm = model_step(m_lo, m_hi, m_ctrl, m_hsel, ph, pl);
        m_lo = nm[7:0]; m_hi = nm[15:8];
      end
      rd(2, a); chk("R2 R4 R5 R7 random lo", a, m_lo);
      rd(3, a); chk("R3 R5 R8 random hi", a, m_hi);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule